// File: doc/BRIEF.md
# Page-Mode DRAM Controller

This controller joins a simple synchronous request port to an asynchronous DRAM that shares its address pins between row and column. A requester raises `req_valid` together with a write flag, a flat address and write data, and holds them until the controller pulses `req_ready` for one cycle. On that cycle a read returns its data on `req_rdata`. On the memory side, the controller drives active-low row strobes (one per module), a shared column strobe, a write enable, an output enable and a tri-state data bus.

After an access the row stays open. A following request to the same module and row skips row activation: only a new column is driven and the column strobe pulses again. A request to another row or module first closes the open row for a programmable precharge time, then opens the new one. A timer requests a row-only refresh at a fixed interval. Refresh takes precedence over waiting traffic, closes any open row, and steps through every row in order.

Top module: `pgdram_ctrl`

## Requirements
- R1: While reset is held, and directly after it, every row strobe, the column strobe, write enable and output enable are high, the data pins are undriven (Z) and `req_ready` is low.
- R2: `req_addr` is split as {module[MW-1:0], row[AW-1:0], column[AW-1:0]}, with the column in the lowest bits. With the defaults, bits 20:18 are the module, 17:9 the row and 8:0 the column. The row value is on `dram_addr` when a row strobe falls. The column value is on it when `dram_cas_n` falls and stays stable while the column strobe is low.
- R3: For a read or write, exactly one row strobe is low while the column strobe is low. It is bit `module` of `dram_ras_n`, and all other bits stay high.
- R4: A write lowers `dram_we_n` at least one cycle before `dram_cas_n` falls, keeps `dram_oe_n` high, and drives the write data on `dram_dq`. A read keeps `dram_we_n` high, lowers `dram_oe_n` and leaves `dram_dq` undriven.
- R5: `dram_we_n` and `dram_oe_n` are never low in the same cycle.
- R6: A request whose module and row match the open row produces no new row strobe fall. The row strobe stays low and only the column strobe pulses.
- R7: Before any row strobe falls, all row strobes have been high for at least T_RP cycles. A request to a different row or module causes exactly one new row strobe fall.
- R8: The row strobe is low for at least T_RCD cycles before the column strobe falls, and each column strobe pulse lasts exactly T_CAS cycles.
- R9: Each request is answered by a `req_ready` pulse exactly one cycle long. Read data on `req_rdata` in that cycle equals the last data written to that address, or the memory's initial content if the address was never written.
- R10: A refresh lowers all row strobes together while the column strobe stays high. Successive refreshes present rows 0, 1, 2 ... in order, wrap from 511 back to 0, and start no more than REF_PERIOD + 20 cycles apart.
- R11: A pending refresh wins over a waiting request and closes the open row. An access to that row after the refresh reopens it with a new row strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | MW+2*AW | {module, row, column} |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read data, valid with `req_ready` |
| dram_ras_n | output | MODS | Row strobes, one per module, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Shared row/column address |
| dram_dq | inout | DW | Bidirectional data |

## Verification
The embedded properties check, on every clock, that write and output enable never overlap, that exactly one module strobe is low during any column strobe, that write enable is already low when a write's column strobe falls, that the column address holds while the column strobe is low, that refresh never carries a column strobe, and that ready is a single-cycle pulse. Some behaviours can only be shown by the bench's scenarios, through its behavioural DRAM and reference memory. These are data integrity through the address split, page hits that avoid row activation, misses that pay a precharge, the ordered refresh sequence with its wrap from 511 to 0, and refresh pre-empting a stream of page hits.

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl #(
  parameter int AW         = 9,
  parameter int DW         = 8,
  parameter int MODS       = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 2,
  parameter int T_RAS_REF  = 4,
  parameter int REF_PERIOD = 780
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic                          req_write,
  input  logic [$clog2(MODS)+2*AW-1:0]  req_addr,
  input  logic [DW-1:0]                 req_wdata,
  output logic                          req_ready,
  output logic [DW-1:0]                 req_rdata,
  output logic [MODS-1:0]               dram_ras_n,
  output logic                          dram_cas_n,
  output logic                          dram_we_n,
  output logic                          dram_oe_n,
  output logic [AW-1:0]                 dram_addr,
  inout  wire  [DW-1:0]                 dram_dq
);
  localparam int MW   = $clog2(MODS);
  localparam int RQW  = MW + 2*AW;
  localparam int TMAX = T_RCD + T_CAS + T_RP + T_RAS_REF;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RFW  = $clog2(REF_PERIOD + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ROWSET, S_ACT, S_COLSET, S_CAS, S_OPEN, S_REFSET, S_REF
  } st_t;

  st_t             state;
  logic [TW-1:0]   tmr;
  logic [RFW-1:0]  ref_tmr;
  logic            ref_pend;
  logic [AW-1:0]   ref_row;
  logic [MW-1:0]   open_mod;
  logic [AW-1:0]   open_row, col_q;
  logic            wr_q;
  logic [DW-1:0]   wdata_q;
  logic            dq_en;
  logic            ready_q;

  wire [MW-1:0] rq_mod = req_addr[RQW-1 -: MW];
  wire [AW-1:0] rq_row = req_addr[2*AW-1 -: AW];
  wire [AW-1:0] rq_col = req_addr[AW-1:0];
  wire          hit    = (rq_mod == open_mod) && (rq_row == open_row);
  wire          take   = req_valid && !ready_q;

  assign dram_dq   = dq_en ? wdata_q : {DW{1'bz}};
  assign req_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tmr        <= '0;
      ref_tmr    <= RFW'(REF_PERIOD - 1);
      ref_pend   <= 1'b0;
      ref_row    <= '0;
      open_mod   <= '0;
      open_row   <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      wdata_q    <= '0;
      dq_en      <= 1'b0;
      ready_q    <= 1'b0;
      req_rdata  <= '0;
      dram_ras_n <= '1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_addr  <= '0;
    end else begin
      ready_q <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            dram_addr <= ref_row;
            ref_pend  <= 1'b0;
            state     <= S_REFSET;
          end else if (take) begin
            open_mod  <= rq_mod;
            open_row  <= rq_row;
            col_q     <= rq_col;
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            dram_addr <= rq_row;
            state     <= S_ROWSET;
          end
        end
        S_REFSET: begin
          dram_ras_n <= '0;
          ref_row    <= ref_row + 1'b1;
          tmr        <= TW'(T_RAS_REF - 1);
          state      <= S_REF;
        end
        S_REF: if (tmr == '0) begin
          dram_ras_n <= '1;
          tmr        <= TW'(T_RP - 1);
          state      <= S_PRE;
        end
        S_PRE: if (tmr == '0) state <= S_IDLE;
        S_ROWSET: begin
          dram_ras_n <= ~(MODS'(1) << open_mod);
          tmr        <= TW'(T_RCD - 1);
          state      <= S_ACT;
        end
        S_ACT: if (tmr == '0) begin
          dram_addr <= col_q;
          dram_we_n <= ~wr_q;
          dram_oe_n <= wr_q;
          dq_en     <= wr_q;
          state     <= S_COLSET;
        end
        S_COLSET: begin
          dram_cas_n <= 1'b0;
          tmr        <= TW'(T_CAS - 1);
          state      <= S_CAS;
        end
        S_CAS: if (tmr == '0) begin
          if (!wr_q) req_rdata <= dram_dq;
          dram_cas_n <= 1'b1;
          dram_we_n  <= 1'b1;
          dram_oe_n  <= 1'b1;
          dq_en      <= 1'b0;
          ready_q    <= 1'b1;
          state      <= S_OPEN;
        end
        S_OPEN: begin
          if (ref_pend || (take && !hit)) begin
            dram_ras_n <= '1;
            tmr        <= TW'(T_RP - 1);
            state      <= S_PRE;
          end else if (take) begin
            col_q     <= rq_col;
            wr_q      <= req_write;
            wdata_q   <= req_wdata;
            dram_addr <= rq_col;
            dram_we_n <= ~req_write;
            dram_oe_n <= req_write;
            dq_en     <= req_write;
            state     <= S_COLSET;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (ref_tmr == '0) begin
        ref_tmr  <= RFW'(REF_PERIOD - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dram_we_n && !dram_oe_n)); // R5
  AST_ONE_RAS_AT_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> ($countones(~dram_ras_n) == 1)); // R3
  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(dram_we_n) == 1'b0)); // R4
  AST_COL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && !$fell(dram_cas_n)) |-> $stable(dram_addr)); // R2
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n == '0) |-> dram_cas_n); // R10
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R9
endmodule

// File: tb/sim_pgdram_ctrl.sv
`timescale 1ns/1ps
module sim_pgdram_ctrl;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RAS_REF = 3, REF_P = 150;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready;
  logic [7:0]  req_rdata;
  logic [7:0]  ras_n;
  logic        cas_n, we_n, oe_n;
  logic [8:0]  daddr;
  wire  [7:0]  dq;
  logic        drv = 0;
  logic [7:0]  drv_val = '0;
  assign dq = drv ? drv_val : 8'bz;

  pgdram_ctrl #(.AW(9), .DW(8), .MODS(8), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
                .T_RAS_REF(T_RAS_REF), .REF_PERIOD(REF_P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(daddr), .dram_dq(dq));

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int key);
    return key[7:0] ^ key[15:8] ^ {3'b0, key[20:16]} ^ 8'hA5;
  endfunction

  logic [7:0] dram_mem [int];
  logic [7:0] gold [int];
  logic [20:0] cur_addr = '0;
  logic [7:0]  cur_wdata = '0;
  bit          cur_wr = 0;

  logic [7:0] prev_ras = 8'hFF;
  logic       prev_cas = 1, prev_we = 1;
  int hi_run = 1000, ras_low_run = 0, cas_low_run = 0, cyc = 0;
  int ras_falls = 0, ref_cnt = 0, last_ref = 0, exp_ref_row = 0;
  bit wrap_seen = 0;
  int act_mod = 0;
  logic [8:0] act_row = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] fell;
      cyc++;
      fell = prev_ras & ~ras_n;
      check(!(!we_n && !oe_n), "R5", "we/oe overlap", {we_n, oe_n}, 3);
      if (fell != 0) begin
        check(hi_run >= T_RP, "R7", "precharge cycles", hi_run, T_RP);
        if (ras_n == 8'h00) begin
          check(daddr == 9'(exp_ref_row), "R10", "refresh row", daddr, exp_ref_row);
          if (ref_cnt > 0 && daddr == 0) wrap_seen = 1;
          exp_ref_row = (exp_ref_row + 1) % 512;
          if (ref_cnt > 0)
            check(cyc - last_ref <= REF_P + 20, "R10", "refresh interval", cyc - last_ref, REF_P + 20);
          last_ref = cyc;
          ref_cnt++;
        end else begin
          check($countones(~ras_n) == 1, "R3", "row strobes low", $countones(~ras_n), 1);
          for (int i = 0; i < 8; i++) if (!ras_n[i]) act_mod = i;
          act_row = daddr;
          ras_falls++;
        end
      end
      if (ras_n == 8'h00)
        check(cas_n, "R10", "cas during refresh", cas_n, 1);
      if (prev_cas && !cas_n) begin
        int key;
        check(ras_low_run >= T_RCD, "R8", "ras-to-cas cycles", ras_low_run, T_RCD);
        check(act_mod == int'(cur_addr[20:18]), "R3", "module strobe", act_mod, cur_addr[20:18]);
        check(act_row == cur_addr[17:9], "R2", "row at ras fall", act_row, cur_addr[17:9]);
        check(daddr == cur_addr[8:0], "R2", "column at cas fall", daddr, cur_addr[8:0]);
        key = {11'b0, 3'(act_mod), act_row, daddr};
        if (!we_n) begin
          check(prev_we == 0, "R4", "we low before cas", prev_we, 0);
          check(oe_n == 1, "R4", "oe during write", oe_n, 1);
          check(dq === cur_wdata, "R4", "write data on pins", dq, cur_wdata);
          dram_mem[key] = dq;
        end else begin
          check(oe_n == 0, "R4", "oe during read", oe_n, 0);
          drv_val = dram_mem.exists(key) ? dram_mem[key] : init_val(key);
          drv = 1;
        end
      end
      if (!prev_cas && cas_n) begin
        check(cas_low_run == T_CAS, "R8", "cas pulse cycles", cas_low_run, T_CAS);
        drv = 0;
      end
      hi_run      = (ras_n == 8'hFF) ? hi_run + 1 : 0;
      ras_low_run = (ras_n != 8'hFF) ? ras_low_run + 1 : 0;
      cas_low_run = !cas_n ? cas_low_run + 1 : 0;
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n;
    end
  end

  function automatic logic [20:0] mk(input int m, input int r, input int c);
    return {3'(m), 9'(r), 9'(c)};
  endfunction

  task automatic do_req(input bit wr, input logic [20:0] a, input logic [7:0] d, output logic [7:0] rd);
    int guard = 0;
    @(negedge clk);
    cur_addr = a; cur_wdata = d; cur_wr = wr;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    do begin @(negedge clk); guard++; end while (!req_ready && guard < 2000);
    check(guard < 2000, "R9", "ready timeout", guard, 0);
    rd = req_rdata;
    req_valid = 0;
    if (wr) gold[int'(a)] = d;
    @(negedge clk);
    check(!req_ready, "R9", "ready pulse width", req_ready, 0);
  endtask

  task automatic wr(input logic [20:0] a, input logic [7:0] d);
    logic [7:0] rd;
    do_req(1, a, d, rd);
  endtask

  task automatic rd_chk(input logic [20:0] a, input string tag);
    logic [7:0] rd, exp;
    do_req(0, a, 8'h00, rd);
    exp = gold.exists(int'(a)) ? gold[int'(a)] : init_val(int'(a));
    check(rd === exp, tag, "read data", rd, exp);
  endtask

  initial begin
    repeat (20000 * 10) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int f0, f1, r0;
    repeat (3) @(negedge clk);
    check(ras_n == 8'hFF, "R1", "ras in reset", ras_n, 255);
    check(cas_n && we_n && oe_n, "R1", "strobes in reset", {cas_n, we_n, oe_n}, 7);
    check(dq === 8'bz, "R1", "dq released in reset", dq, 0);
    check(!req_ready, "R1", "ready in reset", req_ready, 0);
    rst_n = 1;
    @(negedge clk);
    check(ras_n == 8'hFF && cas_n, "R1", "strobes after reset", {ras_n, cas_n}, 511);

    // page hits: R6
    f0 = ras_falls;
    wr(mk(2, 5, 10), 8'h3C);
    f1 = ras_falls;
    check(f1 == f0 + 1, "R7", "first access opens row", f1 - f0, 1);
    rd_chk(mk(2, 5, 10), "R9");
    wr(mk(2, 5, 11), 8'hC3);
    wr(mk(2, 5, 300), 8'h81);
    rd_chk(mk(2, 5, 11), "R9");
    rd_chk(mk(2, 5, 300), "R9");
    rd_chk(mk(2, 5, 12), "R2");
    check(ras_falls == f1, "R6", "no ras fall on page hits", ras_falls - f1, 0);

    // miss on row, then on module: R7 R3
    f0 = ras_falls;
    wr(mk(2, 6, 10), 8'h11);
    check(ras_falls == f0 + 1, "R7", "row miss reopens", ras_falls - f0, 1);
    f0 = ras_falls;
    wr(mk(5, 6, 10), 8'h22);
    check(ras_falls == f0 + 1, "R7", "module miss reopens", ras_falls - f0, 1);
    rd_chk(mk(2, 6, 10), "R9");
    rd_chk(mk(5, 6, 10), "R3");
    rd_chk(mk(2, 5, 10), "R9");

    // corners: R2
    wr(mk(7, 511, 511), 8'hFE);
    wr(mk(0, 0, 0), 8'h01);
    rd_chk(mk(7, 511, 511), "R2");
    rd_chk(mk(0, 0, 0), "R2");
    rd_chk(mk(4, 257, 129), "R2");

    // idle refresh: R10
    r0 = ref_cnt;
    repeat (3 * REF_P + 20) @(negedge clk);
    check(ref_cnt - r0 >= 3, "R10", "refreshes while idle", ref_cnt - r0, 3);

    // stream of page hits across refreshes: R11
    r0 = ref_cnt; f0 = ras_falls;
    for (int k = 0; k < 120; k++) begin
      if (k % 2 == 0) wr(mk(3, 40, k), 8'(k * 7));
      else rd_chk(mk(3, 40, k - 1), "R11");
    end
    check(ref_cnt - r0 >= 2, "R11", "refresh during stream", ref_cnt - r0, 2);
    check(ras_falls - f0 == 1 + ref_cnt - r0, "R11", "row reopened after refresh",
          ras_falls - f0, 1 + ref_cnt - r0);

    // wrap of refresh row: R10
    while (ref_cnt < 515) @(negedge clk);
    check(wrap_seen, "R10", "refresh row wrapped to 0", wrap_seen, 1);
    rd_chk(mk(7, 511, 511), "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule